// File: doc/BRIEF.md
# Wide Word Normalizer

This block left-aligns a 64-bit mantissa in a single clock. The leading one (the most significant set bit) of the input word is moved to the top bit position, and the number of positions it was moved is reported. The datapath is divided into banks. Bank k sees the input word already moved left by 16·k positions, with zeros shifted in. Each bank is a row of 16-bit output slices. Every slice reads a 32-bit window, made of its own 16 bits and the 16 bits below them, and applies a shift of 0 to 15 positions. All slices in a bank use the same shift, which comes from a leading-one encoder on the bank's topmost window.

A bank is eligible when its leading one falls in its upper 16 positions. The lowest-numbered eligible bank drives the result onto an AND-OR bus. Banks that are not selected gate their upper slices to zero. The bottom slice of each bank is never gated. Instead, the top bit of its shift code is forced high whenever its bank is not selected, so it outputs zeros; this is what fills the low part of the result with zeros. The reported shift count is the selected bank's number followed by that bank's 4-bit in-bank shift.

The result, the shift count and an all-zero flag are registered once at the output. The block uses an asynchronous active-low reset that is released through a two-stage synchronizer.

Top module: `wide_normalizer`

## Requirements
- R1: For a nonzero input, `norm_word` equals the input shifted left by its leading-zero count, so `norm_word[63]` is 1.
- R2: For a nonzero input, `lead_cnt` equals the number of zero bits above the input's most significant set bit (0 to 63).
- R3: `lead_cnt[5:4]` holds the selected bank number. It equals the leading-zero count divided by 16, so crossing 16, 32 or 48 leading zeros moves the result to the next bank.
- R4: `lead_cnt[3:0]` holds the in-bank shift. It equals the leading-zero count modulo 16 and is shared by every slice of the selected bank.
- R5: An all-zero input gives `norm_word` = 0, `lead_cnt` = 63 and `is_zero` = 1. For any nonzero input, `is_zero` is 0.
- R6: All three outputs are registered. They show the result for the input sampled at the previous rising clock edge.
- R7: While reset is low, and until the first rising edge after the synchronized release, the outputs hold 0, 63 and 1. This holds even if the input is nonzero at that time.
- R8: Every output bit below position `lead_cnt` is zero. This zero fill comes from the gated slices and the forced bottom slices of the banks that are not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| raw_word | input | 64 | Word to be normalized |
| norm_word | output | 64 | Left-aligned word, registered |
| lead_cnt | output | 6 | Total shift applied: {bank, in-bank shift}, registered |
| is_zero | output | 1 | Input word was all zeros, registered |

## Verification
The bench builds the block with its default parameters: 16-bit slices and four banks. With these values every leading-one position from 63 down to 0 is within reach, and so is every bank boundary at 16, 32 and 48 leading zeros. The sparsely populated lower banks, whose low slices must zero-fill from a higher bank, are exercised as well. Walking single bits, ones-filled tails below the leading bit, and random words scaled across the full range drive each bank in turn, including the bank that holds a single slice.

// File: rtl/wnorm_pkg.sv
package wnorm_pkg;

  localparam int unsigned DEF_SLICE_W = 16;
  localparam int unsigned DEF_BANKS   = 4;

  // Role of a slice inside its bank: the bottom slice is never gated and
  // produces zero fill by having its shift pushed past the slice width.
  typedef enum logic {
    SLICE_INNER = 1'b0,
    SLICE_LOW   = 1'b1
  } slice_role_e;

endpackage

// File: rtl/wnorm_rst_sync.sv
module wnorm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      hold_q  <= stage_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/wnorm_lead_enc.sv
module wnorm_lead_enc #(
  parameter int unsigned WIN_W  = 32,
  parameter int unsigned CODE_W = $clog2(WIN_W)
) (
  input  logic [WIN_W-1:0]  win,
  output logic [CODE_W-1:0] lz
);

  // Number of positions needed to bring the highest set bit to the top;
  // an empty window reports the largest code.
  always_comb begin
    lz = CODE_W'(WIN_W - 1);
    for (int i = 0; i < int'(WIN_W); i++) begin
      if (win[i]) lz = CODE_W'(int'(WIN_W) - 1 - i);
    end
  end

endmodule

// File: rtl/wnorm_slice.sv
module wnorm_slice
  import wnorm_pkg::*;
#(
  parameter int unsigned  SLICE_W = DEF_SLICE_W,
  parameter slice_role_e  ROLE    = SLICE_INNER,
  localparam int unsigned STEP_W  = $clog2(SLICE_W),
  localparam int unsigned CODE_W  = STEP_W + 1
) (
  input  logic [2*SLICE_W-1:0] win,
  input  logic [STEP_W-1:0]    step,
  input  logic                 bank_sel,
  output logic [SLICE_W-1:0]   y
);

  logic [CODE_W-1:0]  code;
  logic [SLICE_W-1:0] moved;

  // Upper half of the window after a left move by 'code'; positions with
  // no source bit become zero.
  always_comb begin
    for (int i = 0; i < int'(SLICE_W); i++) begin
      int src;
      src = int'(SLICE_W) + i - int'(code);
      moved[i] = (src >= 0) ? win[src] : 1'b0;
    end
  end

  if (ROLE == SLICE_LOW) begin : g_low
    // Deselected: code >= SLICE_W moves only zero fill into the output.
    assign code = {~bank_sel, step};
    assign y    = moved;
  end else begin : g_inner
    assign code = {1'b0, step};
    assign y    = moved & {SLICE_W{bank_sel}};
  end

endmodule

// File: rtl/wnorm_bank.sv
module wnorm_bank
  import wnorm_pkg::*;
#(
  parameter int unsigned  SLICE_W  = DEF_SLICE_W,
  parameter int unsigned  BANKS    = DEF_BANKS,
  parameter int unsigned  BANK_IDX = 0,
  localparam int unsigned WORD_W   = SLICE_W * BANKS,
  localparam int unsigned IN_W     = SLICE_W * (BANKS - BANK_IDX),
  localparam int unsigned STEP_W   = $clog2(SLICE_W),
  localparam int unsigned CODE_W   = STEP_W + 1
) (
  input  logic [IN_W-1:0]   din_part,
  input  logic              bank_sel,
  output logic [WORD_W-1:0] contrib,
  output logic              qualify,
  output logic [STEP_W-1:0] step
);

  logic [2*SLICE_W-1:0] top_win;
  logic [CODE_W-1:0]    top_lz;

  // Window of the topmost slice of this pre-shifted bank.
  if (BANK_IDX == BANKS - 1) begin : g_top_single
    assign top_win = {din_part[SLICE_W-1:0], {SLICE_W{1'b0}}};
  end else begin : g_top_multi
    assign top_win = din_part[IN_W-1 -: 2*SLICE_W];
  end

  wnorm_lead_enc #(
    .WIN_W  (2 * SLICE_W),
    .CODE_W (CODE_W)
  ) u_enc (
    .win (top_win),
    .lz  (top_lz)
  );

  // Leading one within the upper half of the window: shift fits in 0..15.
  assign qualify = ~top_lz[CODE_W-1];
  assign step    = top_lz[STEP_W-1:0];

  for (genvar j = 0; j < int'(BANKS); j++) begin : g_pos
    if (j < int'(BANK_IDX)) begin : g_absent
      assign contrib[j*SLICE_W +: SLICE_W] = '0;
    end else if (j == int'(BANK_IDX)) begin : g_bottom
      logic [2*SLICE_W-1:0] win_j;
      assign win_j = {din_part[SLICE_W-1:0], {SLICE_W{1'b0}}};
      wnorm_slice #(
        .SLICE_W (SLICE_W),
        .ROLE    (SLICE_LOW)
      ) u_slice (
        .win      (win_j),
        .step     (step),
        .bank_sel (bank_sel),
        .y        (contrib[j*SLICE_W +: SLICE_W])
      );
    end else begin : g_upper
      logic [2*SLICE_W-1:0] win_j;
      assign win_j = din_part[SLICE_W*(j+1-int'(BANK_IDX))-1 -: 2*SLICE_W];
      wnorm_slice #(
        .SLICE_W (SLICE_W),
        .ROLE    (SLICE_INNER)
      ) u_slice (
        .win      (win_j),
        .step     (step),
        .bank_sel (bank_sel),
        .y        (contrib[j*SLICE_W +: SLICE_W])
      );
    end
  end

endmodule

// File: rtl/wide_normalizer.sv
module wide_normalizer
  import wnorm_pkg::*;
#(
  parameter int unsigned  SLICE_W = DEF_SLICE_W,
  parameter int unsigned  BANKS   = DEF_BANKS,
  localparam int unsigned WORD_W  = SLICE_W * BANKS,
  localparam int unsigned STEP_W  = $clog2(SLICE_W),
  localparam int unsigned BIDX_W  = $clog2(BANKS),
  localparam int unsigned CNT_W   = STEP_W + BIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] raw_word,
  output logic [WORD_W-1:0] norm_word,
  output logic [CNT_W-1:0]  lead_cnt,
  output logic              is_zero
);

  logic rst_sn;

  wnorm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sn)
  );

  logic [BANKS-1:0]             bank_ok;
  logic [BANKS-1:0]             bank_pick;
  logic [BANKS-1:0][STEP_W-1:0] bank_step;
  logic [BANKS-1:0][WORD_W-1:0] bank_out;

  for (genvar b = 0; b < int'(BANKS); b++) begin : g_bank
    wnorm_bank #(
      .SLICE_W  (SLICE_W),
      .BANKS    (BANKS),
      .BANK_IDX (b)
    ) u_bank (
      .din_part (raw_word[SLICE_W*(int'(BANKS)-b)-1:0]),
      .bank_sel (bank_pick[b]),
      .contrib  (bank_out[b]),
      .qualify  (bank_ok[b]),
      .step     (bank_step[b])
    );
  end

  // Lowest-numbered eligible bank wins (fewest leading zeros).
  logic pick_found;
  always_comb begin
    pick_found = 1'b0;
    bank_pick  = '0;
    for (int b = 0; b < int'(BANKS); b++) begin
      if (bank_ok[b] && !pick_found) begin
        bank_pick[b] = 1'b1;
        pick_found   = 1'b1;
      end
    end
  end

  // AND-OR bus replacing per-bank tri-state drivers.
  logic [WORD_W-1:0] word_nxt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic              zero_nxt;

  always_comb begin
    word_nxt = '0;
    cnt_nxt  = '1;
    for (int b = 0; b < int'(BANKS); b++) begin
      word_nxt = word_nxt | bank_out[b];
      if (bank_pick[b]) cnt_nxt = {BIDX_W'(b), bank_step[b]};
    end
    zero_nxt = ~pick_found;
  end

  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              zero_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      word_q <= '0;
      cnt_q  <= '1;
      zero_q <= 1'b1;
    end else begin
      word_q <= word_nxt;
      cnt_q  <= cnt_nxt;
      zero_q <= zero_nxt;
    end
  end

  assign norm_word = word_q;
  assign lead_cnt  = cnt_q;
  assign is_zero   = zero_q;

  // ------------------------------------------------------------------
  // Assertions
  // ------------------------------------------------------------------
  logic armed_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  a_r1_lead_top: assert property (@(posedge clk) disable iff (!rst_sn)
    !zero_q |-> word_q[WORD_W-1]);

  a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_sn)
    (armed_q && !zero_q) |-> (word_q == ($past(raw_word) << cnt_q)));

  a_r5_zero_out: assert property (@(posedge clk) disable iff (!rst_sn)
    zero_q |-> ((word_q == '0) && (cnt_q == '1)));

  a_r5_zero_src: assert property (@(posedge clk) disable iff (!rst_sn)
    armed_q |-> (zero_q == ($past(raw_word) == '0)));

  a_r8_low_fill: assert property (@(posedge clk) disable iff (!rst_sn)
    !zero_q |-> ((word_q & ~({WORD_W{1'b1}} << cnt_q)) == '0));

  for (genvar b = 0; b < int'(BANKS); b++) begin : g_chk
    a_r8_idle_bank: assert property (@(posedge clk) disable iff (!rst_sn)
      !bank_pick[b] |-> (bank_out[b] == '0));
  end

endmodule

// File: tb/sim_wide_normalizer.sv
`timescale 1ns/1ps
module sim_wide_normalizer;

  localparam int W = 64;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] raw_word;
  logic [W-1:0] norm_word;
  logic [5:0]   lead_cnt;
  logic         is_zero;

  int n_vec;
  int n_bad;
  logic [W-1:0] prev_word;

  wide_normalizer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_word  (raw_word),
    .norm_word (norm_word),
    .lead_cnt  (lead_cnt),
    .is_zero   (is_zero)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int ref_lz(logic [W-1:0] v);
    int n;
    n = 0;
    for (int i = W - 1; i >= 0; i--) begin
      if (v[i]) return n;
      n++;
    end
    return W;
  endfunction

  task automatic expect_eq(string tag, logic [W-1:0] got, logic [W-1:0] want);
    n_vec++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (input %h)", tag, got, want, prev_word);
    end
  endtask

  // Compare outputs against the reference for the word captured last edge.
  task automatic check_prev();
    int lz;
    logic [W-1:0] exp_word;
    logic [5:0]   exp_cnt;
    lz       = ref_lz(prev_word);
    exp_word = (lz == W) ? '0 : (prev_word << lz);
    exp_cnt  = (lz == W) ? 6'd63 : 6'(lz);
    expect_eq("R1 R6 word", norm_word, exp_word);
    expect_eq("R2 count", W'(lead_cnt), W'(exp_cnt));
    expect_eq("R3 bank", W'(lead_cnt[5:4]), W'(exp_cnt[5:4]));
    expect_eq("R4 step", W'(lead_cnt[3:0]), W'(exp_cnt[3:0]));
    expect_eq("R5 flag", W'(is_zero), W'(lz == W));
    expect_eq("R8 fill", norm_word & ~({W{1'b1}} << lead_cnt), '0);
  endtask

  task automatic apply(logic [W-1:0] v);
    @(negedge clk);
    check_prev();
    prev_word = v;
    raw_word  = v;
  endtask

  task automatic check_reset_state(string tag);
    expect_eq({tag, " word"}, norm_word, '0);
    expect_eq({tag, " count"}, W'(lead_cnt), W'(6'd63));
    expect_eq({tag, " flag"}, W'(is_zero), W'(1'b1));
  endtask

  initial begin
    n_vec = 0;
    n_bad = 0;
    prev_word = '0;
    rst_n = 1'b0;
    raw_word = 64'hDEAD_BEEF_0000_1234;
    repeat (3) @(negedge clk);
    check_reset_state("R7 in reset");
    raw_word = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("R7 after release");
    repeat (3) @(negedge clk);

    apply('0);
    apply({W{1'b1}});
    apply('0);
    // Walking single bit: every leading position, every bank.
    for (int i = 0; i < W; i++) apply(64'd1 << i);
    // Leading one with all ones beneath.
    for (int i = 0; i < W; i++) apply({W{1'b1}} >> i);
    // Bank boundaries (R3): 15/16, 31/32, 47/48 leading zeros.
    apply(64'h0001_0000_0000_0001);
    apply(64'h0000_FFFF_FFFF_FFFF);
    apply(64'h0000_0001_8000_0000);
    apply(64'h0000_0000_FFFF_0000);
    apply(64'h0000_0000_0001_0000);
    apply(64'h0000_0000_0000_8001);
    apply(64'h0000_0000_0000_0001);
    // Random words spread over all leading-zero counts.
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] r;
      r = {$urandom(), $urandom()};
      apply(r >> ($urandom() % W));
    end
    apply('0);
    apply('0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule